// File: doc/BRIEF.md
# Segment Descriptor Load Validator

This unit checks and decodes one segment descriptor while a task switch reloads its segment registers. A caller presents a 16-bit selector, the kind of register being loaded (code, stack or data), the current privilege level, and the base and limit of the global and local descriptor tables, then pulses `start`. The unit works out where the 8-byte descriptor lives and fetches it as two 32-bit words over a simple request/acknowledge read port. It then applies the type and privilege rules for that register kind.

One cycle after the second word is accepted, the unit settles. It pulses `done` for a single cycle. At that point it either asserts `ok` together with the decoded base, the expanded limit and the raw attribute word, or asserts `fault` together with a fault class and an error code derived from the selector. Results hold until the next request completes.

Top module: `segld_top`

## Requirements
- R1: Selector bit 2 picks the local table (set) or the global table (clear). The byte index is the selector with bits 2:0 cleared. The low descriptor word is read at table base + index, and the high word is read at base + index + 4, in that order.
- R2: A selector with bits 15:2 all zero is a null selector, and no memory read is made for it. For a data target (tgt = 0, or 3), the load completes with `ok` and base, limit and flags all zero. For a code target (tgt = 1) or a stack target (tgt = 2), it faults with class 1 (invalid task state) and error code 0.
- R3: When index + 7 is greater than the chosen table limit, the load faults with class 1 and no memory read is made.
- R4: A descriptor whose S bit (high word bit 12) is clear faults with class 1. Every fault raised for a non-null selector carries the error code `sel & 16'hFFFC`.
- R5: For a code target, the load faults with class 1 in three cases: the descriptor is not code (type bit 3, high word bit 11, is clear); its DPL (high word bits 14:13) differs from the selector RPL (bits 1:0); or it is conforming (type bit 2) with DPL greater than RPL.
- R6: For a stack target, the load faults with class 1 if the descriptor is code, or if its writable bit (type bit 1) is clear, or if its DPL differs from either CPL or RPL.
- R7: For a data target, the load faults with class 1 if the descriptor is code with the readable bit (type bit 1) clear. When the 4-bit type is below 12, it also faults if DPL is less than CPL or less than RPL. Conforming code (type 12 and above) skips the privilege test.
- R8: The present bit (high word bit 15) is tested only after every type and privilege test has passed. A clear present bit then gives class 2 (segment not present), and any class-1 condition takes precedence over it.
- R9: The limit is low word bits 15:0 joined with high word bits 19:16. When G (high word bit 23) is set, this 20-bit value is shifted left by 12 and the low 12 bits are filled with ones.
- R10: The base is {high[31:24], high[7:0], low[31:16]}. On success, `seg_flags` equals the high descriptor word.
- R11: `done` is high for exactly one cycle per request, and exactly one of `ok`/`fault` is high with it. `busy` is high from the cycle after an accepted `start` until `done`. A `start` while busy is ignored. The read address holds steady while a request waits for its acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load (taken only when idle) |
| sel | input | 16 | Selector to load |
| tgt | input | 2 | Target kind: 0 data, 1 code, 2 stack, 3 data |
| cpl | input | 2 | Current privilege level |
| gdt_base | input | ADDR_W | Global table base address |
| gdt_lim | input | ADDR_W | Global table limit |
| ldt_base | input | ADDR_W | Local table base address |
| ldt_lim | input | ADDR_W | Local table limit |
| mem_req | output | 1 | Read request |
| mem_addr | output | ADDR_W | Read byte address |
| mem_ack | input | 1 | Read accepted, data valid this cycle |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Load accepted |
| fault | output | 1 | Load rejected |
| fault_kind | output | 2 | 1 invalid task state, 2 not present |
| err_code | output | 16 | Selector-derived error code |
| seg_base | output | ADDR_W | Decoded base |
| seg_limit | output | 32 | Expanded limit |
| seg_flags | output | 32 | High descriptor word |

## Verification
The order of the tests is the hardest thing to observe at the ports. A descriptor that is both absent and of the wrong type must report the type fault and not the absent fault. The stimulus reaches this case by loading a non-present writable data descriptor into the code register. The same descriptor is then loaded into the stack register, where it passes every type test, so the only difference between the two outcomes is the ordering.

A second case that needs care is a `start` that arrives mid-fetch. The bench stalls the acknowledge to hold the unit in its read state, fires a second `start` with a different selector, and confirms that exactly one result appears and that it belongs to the first selector.

// File: rtl/segld_pkg.sv
package segld_pkg;
  typedef enum logic [1:0] {
    TGT_DATA  = 2'd0,
    TGT_CODE  = 2'd1,
    TGT_STACK = 2'd2,
    TGT_DATA2 = 2'd3
  } tgt_e;

  typedef enum logic [1:0] {
    FK_NONE   = 2'd0,
    FK_TASK   = 2'd1,
    FK_ABSENT = 2'd2
  } fkind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOK, ST_RD0, ST_RD1, ST_EVAL, ST_FIN
  } walk_st_e;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned SEL_W  = 16;
endpackage

// File: rtl/segld_rules.sv
module segld_rules
  import segld_pkg::*;
(
  input  logic [WORD_W-1:0] hi_word,
  input  logic [SEL_W-1:0]  sel,
  input  logic [1:0]        tgt,
  input  logic [1:0]        cpl,
  output logic              ts_fail,
  output logic              np_fail
);
  logic       s_bit, present, is_code, conf, rw_bit;
  logic [1:0] dpl, rpl;
  logic [3:0] dtype;
  logic       cs_bad, ss_bad, ds_bad;

  always_comb begin
    s_bit   = hi_word[12];
    present = hi_word[15];
    dpl     = hi_word[14:13];
    dtype   = hi_word[11:8];
    is_code = dtype[3];
    conf    = dtype[2];
    rw_bit  = dtype[1];
    rpl     = sel[1:0];

    cs_bad = !is_code || (dpl != rpl) || (conf && (dpl > rpl));
    ss_bad = is_code || !rw_bit || (dpl != cpl) || (dpl != rpl);
    ds_bad = (is_code && !rw_bit) ||
             ((dtype < 4'd12) && ((dpl < cpl) || (dpl < rpl)));

    ts_fail = !s_bit;
    unique case (tgt)
      TGT_CODE:  ts_fail = ts_fail || cs_bad;
      TGT_STACK: ts_fail = ts_fail || ss_bad;
      default:   ts_fail = ts_fail || ds_bad;
    endcase
    np_fail = !present;
  end
endmodule

// File: rtl/segld_decode.sv
module segld_decode
  import segld_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [WORD_W-1:0] lo_word,
  input  logic [WORD_W-1:0] hi_word,
  output logic [ADDR_W-1:0] base,
  output logic [WORD_W-1:0] limit
);
  localparam int unsigned RAW_W = 20;
  logic [RAW_W-1:0] raw_lim;
  logic [31:0]      full_base;

  always_comb begin
    raw_lim   = {hi_word[19:16], lo_word[15:0]};
    full_base = {hi_word[31:24], hi_word[7:0], lo_word[31:16]};
    base      = ADDR_W'(full_base);
    if (hi_word[23]) limit = {raw_lim, 12'hFFF};
    else             limit = {{(WORD_W-RAW_W){1'b0}}, raw_lim};
  end
endmodule

// File: rtl/segld_walk.sv
module segld_walk
  import segld_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SEL_W-1:0]  sel,
  input  logic [1:0]        tgt,
  input  logic [1:0]        cpl,
  input  logic [ADDR_W-1:0] gdt_base,
  input  logic [ADDR_W-1:0] gdt_lim,
  input  logic [ADDR_W-1:0] ldt_base,
  input  logic [ADDR_W-1:0] ldt_lim,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] lo_q,
  output logic [WORD_W-1:0] hi_q,
  output logic [SEL_W-1:0]  sel_q,
  output logic [1:0]        tgt_q,
  output logic [1:0]        cpl_q,
  input  logic              ts_fail,
  input  logic              np_fail,
  input  logic [ADDR_W-1:0] dec_base,
  input  logic [WORD_W-1:0] dec_limit,
  output logic              busy,
  output logic              done,
  output logic              ok,
  output logic              fault,
  output logic [1:0]        fault_kind,
  output logic [SEL_W-1:0]  err_code,
  output logic [ADDR_W-1:0] seg_base,
  output logic [WORD_W-1:0] seg_limit,
  output logic [WORD_W-1:0] seg_flags
);
  walk_st_e          st, st_n;
  logic [ADDR_W-1:0] tbase_q, tlim_q, addr_q, idx, addr_n;
  logic [ADDR_W:0]   span;
  logic              is_null, oob, latch_in, lo_en, hi_en, addr_en;
  logic              res_en, n_ok, n_fault;
  logic [1:0]        n_kind;
  logic [ADDR_W-1:0] n_base;
  logic [WORD_W-1:0] n_limit, n_flags;

  always_comb begin
    idx      = ADDR_W'({sel_q[SEL_W-1:3], 3'b000});
    span     = {1'b0, idx} + (ADDR_W+1)'(7);
    oob      = span > {1'b0, tlim_q};
    is_null  = (sel_q[SEL_W-1:2] == '0);
    addr_n   = tbase_q + idx;
    mem_req  = (st == ST_RD0) || (st == ST_RD1);
    mem_addr = (st == ST_RD1) ? addr_q + ADDR_W'(4) : addr_q;
    busy     = (st != ST_IDLE);
    done     = (st == ST_FIN);
  end

  always_comb begin
    st_n     = st;
    latch_in = 1'b0;
    lo_en    = 1'b0;
    hi_en    = 1'b0;
    addr_en  = 1'b0;
    res_en   = 1'b0;
    n_ok     = 1'b0;
    n_fault  = 1'b0;
    n_kind   = FK_NONE;
    n_base   = '0;
    n_limit  = '0;
    n_flags  = '0;
    unique case (st)
      ST_IDLE: if (start) begin
        latch_in = 1'b1;
        st_n     = ST_LOOK;
      end
      ST_LOOK: begin
        if (is_null) begin
          res_en = 1'b1;
          st_n   = ST_FIN;
          if ((tgt_q == TGT_CODE) || (tgt_q == TGT_STACK)) begin
            n_fault = 1'b1;
            n_kind  = FK_TASK;
          end else begin
            n_ok = 1'b1;
          end
        end else if (oob) begin
          res_en  = 1'b1;
          n_fault = 1'b1;
          n_kind  = FK_TASK;
          st_n    = ST_FIN;
        end else begin
          addr_en = 1'b1;
          st_n    = ST_RD0;
        end
      end
      ST_RD0: if (mem_ack) begin
        lo_en = 1'b1;
        st_n  = ST_RD1;
      end
      ST_RD1: if (mem_ack) begin
        hi_en = 1'b1;
        st_n  = ST_EVAL;
      end
      ST_EVAL: begin
        res_en = 1'b1;
        st_n   = ST_FIN;
        if (ts_fail) begin
          n_fault = 1'b1;
          n_kind  = FK_TASK;
        end else if (np_fail) begin
          n_fault = 1'b1;
          n_kind  = FK_ABSENT;
        end else begin
          n_ok    = 1'b1;
          n_base  = dec_base;
          n_limit = dec_limit;
          n_flags = hi_q;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      sel_q      <= '0;
      tgt_q      <= '0;
      cpl_q      <= '0;
      tbase_q    <= '0;
      tlim_q     <= '0;
      addr_q     <= '0;
      lo_q       <= '0;
      hi_q       <= '0;
      ok         <= 1'b0;
      fault      <= 1'b0;
      fault_kind <= FK_NONE;
      err_code   <= '0;
      seg_base   <= '0;
      seg_limit  <= '0;
      seg_flags  <= '0;
    end else begin
      st <= st_n;
      if (latch_in) begin
        sel_q   <= sel;
        tgt_q   <= tgt;
        cpl_q   <= cpl;
        tbase_q <= sel[2] ? ldt_base : gdt_base;
        tlim_q  <= sel[2] ? ldt_lim : gdt_lim;
      end
      if (addr_en) addr_q <= addr_n;
      if (lo_en)   lo_q   <= mem_rdata;
      if (hi_en)   hi_q   <= mem_rdata;
      if (res_en) begin
        ok         <= n_ok;
        fault      <= n_fault;
        fault_kind <= n_kind;
        err_code   <= n_fault ? (sel_q & 16'hFFFC) : '0;
        seg_base   <= n_base;
        seg_limit  <= n_limit;
        seg_flags  <= n_flags;
      end
    end
  end
endmodule

// File: rtl/segld_top.sv
module segld_top
  import segld_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [15:0]       sel,
  input  logic [1:0]        tgt,
  input  logic [1:0]        cpl,
  input  logic [ADDR_W-1:0] gdt_base,
  input  logic [ADDR_W-1:0] gdt_lim,
  input  logic [ADDR_W-1:0] ldt_base,
  input  logic [ADDR_W-1:0] ldt_lim,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              ok,
  output logic              fault,
  output logic [1:0]        fault_kind,
  output logic [15:0]       err_code,
  output logic [ADDR_W-1:0] seg_base,
  output logic [31:0]       seg_limit,
  output logic [31:0]       seg_flags
);
  logic [WORD_W-1:0] lo_q, hi_q, dec_limit;
  logic [ADDR_W-1:0] dec_base;
  logic [SEL_W-1:0]  sel_q;
  logic [1:0]        tgt_q, cpl_q;
  logic              ts_fail, np_fail;

  segld_walk #(.ADDR_W(ADDR_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start), .sel(sel), .tgt(tgt), .cpl(cpl),
    .gdt_base(gdt_base), .gdt_lim(gdt_lim), .ldt_base(ldt_base), .ldt_lim(ldt_lim),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .lo_q(lo_q), .hi_q(hi_q), .sel_q(sel_q), .tgt_q(tgt_q), .cpl_q(cpl_q),
    .ts_fail(ts_fail), .np_fail(np_fail), .dec_base(dec_base), .dec_limit(dec_limit),
    .busy(busy), .done(done), .ok(ok), .fault(fault), .fault_kind(fault_kind),
    .err_code(err_code), .seg_base(seg_base), .seg_limit(seg_limit),
    .seg_flags(seg_flags)
  );

  segld_rules u_rules (
    .hi_word(hi_q), .sel(sel_q), .tgt(tgt_q), .cpl(cpl_q),
    .ts_fail(ts_fail), .np_fail(np_fail)
  );

  segld_decode #(.ADDR_W(ADDR_W)) u_decode (
    .lo_word(lo_q), .hi_word(hi_q), .base(dec_base), .limit(dec_limit)
  );
endmodule

// File: rtl/segld_chk.sv
module segld_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              ok,
  input logic              fault,
  input logic [1:0]        fault_kind,
  input logic [15:0]       err_code,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       seg_flags
);
  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R11
  verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ok ^ fault));
  // R11
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R11
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
  // R1
  req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);
  // R4
  err_rpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (err_code[1:0] == 2'b00));
  // R8
  ok_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ok && (seg_flags != 32'd0)) |-> seg_flags[15]);
  // R8
  kind_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> ((fault_kind == 2'd1) || (fault_kind == 2'd2)));
endmodule

bind segld_top segld_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .ok(ok), .fault(fault), .fault_kind(fault_kind), .err_code(err_code),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .seg_flags(seg_flags)
);

// File: tb/segld_top_tb.sv
module segld_top_tb;
  logic        clk, rst_n, start, mem_ack, stall;
  logic [15:0] sel;
  logic [1:0]  tgt, cpl;
  logic [31:0] gdt_base, gdt_lim, ldt_base, ldt_lim, mem_addr, mem_rdata;
  logic        mem_req, busy, done, ok, fault;
  logic [1:0]  fault_kind;
  logic [15:0] err_code;
  logic [31:0] seg_base, seg_limit, seg_flags;

  logic [31:0] gmem [0:15];
  logic [31:0] lmem [0:7];
  logic [31:0] rd_log [0:255];
  int          n_rd, checks, errors, wd;

  segld_top u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sel(sel), .tgt(tgt), .cpl(cpl),
    .gdt_base(gdt_base), .gdt_lim(gdt_lim), .ldt_base(ldt_base), .ldt_lim(ldt_lim),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .ok(ok), .fault(fault), .fault_kind(fault_kind),
    .err_code(err_code), .seg_base(seg_base), .seg_limit(seg_limit),
    .seg_flags(seg_flags)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always_comb begin
    mem_ack   = mem_req && !stall;
    mem_rdata = 32'hDEAD_BEEF;
    if (mem_addr >= 32'h1000 && mem_addr < 32'h1040)
      mem_rdata = gmem[4'((mem_addr - 32'h1000) >> 2)];
    else if (mem_addr >= 32'h2000 && mem_addr < 32'h2020)
      mem_rdata = lmem[3'((mem_addr - 32'h2000) >> 2)];
  end

  initial n_rd = 0;
  always @(posedge clk) if (mem_req && mem_ack) begin
    rd_log[n_rd[7:0]] = mem_addr;
    n_rd = n_rd + 1;
  end

  function automatic logic [63:0] mkd(input logic [31:0] b, input logic [19:0] l,
      input logic [3:0] ty, input logic s, input logic [1:0] dpl,
      input logic p, input logic g);
    logic [31:0] w0, w1;
    w0 = {b[15:0], l[15:0]};
    w1 = {b[31:24], g, 1'b1, 2'b00, l[19:16], p, dpl, s, ty, b[23:16]};
    return {w1, w0};
  endfunction

  task automatic put_g(input int e, input logic [63:0] d);
    gmem[2*e] = d[31:0]; gmem[2*e+1] = d[63:32];
  endtask
  task automatic put_l(input int e, input logic [63:0] d);
    lmem[2*e] = d[31:0]; lmem[2*e+1] = d[63:32];
  endtask

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic run(input logic [15:0] s, input logic [1:0] t, input logic [1:0] c);
    @(negedge clk);
    sel = s; tgt = t; cpl = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && wd < 100000) begin @(negedge clk); wd++; end
  endtask

  task automatic exp_ok(input string rq, input logic [31:0] b, input logic [31:0] l,
                        input logic [31:0] f);
    chk({rq, " ok"}, {31'd0, ok}, 32'd1);
    chk({rq, " base"}, seg_base, b);
    chk({rq, " limit"}, seg_limit, l);
    chk({rq, " flags"}, seg_flags, f);
  endtask

  task automatic exp_flt(input string rq, input logic [1:0] k, input logic [15:0] e);
    chk({rq, " fault"}, {31'd0, fault}, 32'd1);
    chk({rq, " kind"}, {30'd0, fault_kind}, {30'd0, k});
    chk({rq, " err"}, {16'd0, err_code}, {16'd0, e});
  endtask

  task automatic t_reset();
    chk("R11 reset busy", {31'd0, busy}, 32'd0);
    chk("R11 reset done", {31'd0, done}, 32'd0);
    chk("R11 reset req", {31'd0, mem_req}, 32'd0);
  endtask

  task automatic t_gdt_code();
    logic [63:0] d;
    int n0;
    d = mkd(32'h12345678, 20'hABCDE, 4'hA, 1'b1, 2'd0, 1'b1, 1'b0);
    n0 = n_rd;
    run(16'h0008, 2'd1, 2'd0);
    exp_ok("R5 R9 R10 code", 32'h12345678, 32'h000ABCDE, d[63:32]);
    chk("R1 read count", n_rd - n0, 32'd2);
    chk("R1 low addr", rd_log[n0[7:0]], 32'h1008);
    chk("R1 high addr", rd_log[8'(n0 + 1)], 32'h100C);
    @(negedge clk);
    chk("R11 done one cycle", {31'd0, done}, 32'd0);
  endtask

  task automatic t_gran();
    logic [63:0] d;
    d = mkd(32'h00FF0000, 20'h00012, 4'h2, 1'b1, 2'd0, 1'b1, 1'b1);
    run(16'h0010, 2'd0, 2'd0);
    exp_ok("R9 granular", 32'h00FF0000, 32'h00012FFF, d[63:32]);
  endtask

  task automatic t_null();
    int n0;
    n0 = n_rd;
    run(16'h0003, 2'd0, 2'd0);
    exp_ok("R2 null data", 32'd0, 32'd0, 32'd0);
    chk("R2 null no read", n_rd - n0, 32'd0);
    run(16'h0000, 2'd1, 2'd0);
    exp_flt("R2 null code", 2'd1, 16'h0000);
    run(16'h0002, 2'd2, 2'd0);
    exp_flt("R2 null stack", 2'd1, 16'h0000);
  endtask

  task automatic t_bound();
    int n0;
    n0 = n_rd;
    run(16'h0040, 2'd0, 2'd0);
    exp_flt("R3 gdt past end", 2'd1, 16'h0040);
    run(16'h001C, 2'd0, 2'd0);
    exp_flt("R3 ldt past end", 2'd1, 16'h001C);
    chk("R3 no read", n_rd - n0, 32'd0);
    run(16'h0014, 2'd0, 2'd0);
    chk("R3 R1 ldt last entry ok", {31'd0, ok}, 32'd1);
    chk("R3 R1 ldt addr", rd_log[8'(n_rd - 1)], 32'h2014);
  endtask

  task automatic t_sys();
    run(16'h001B, 2'd0, 2'd3);
    exp_flt("R4 system desc", 2'd1, 16'h0018);
  endtask

  task automatic t_cs();
    run(16'h0023, 2'd1, 2'd3);
    chk("R5 conforming dpl=rpl ok", {31'd0, ok}, 32'd1);
    run(16'h0020, 2'd1, 2'd0);
    exp_flt("R5 dpl ne rpl", 2'd1, 16'h0020);
    run(16'h0013, 2'd1, 2'd3);
    exp_flt("R5 not code", 2'd1, 16'h0010);
  endtask

  task automatic t_ss();
    run(16'h0007, 2'd2, 2'd3);
    exp_ok("R6 stack ok", 32'hCAFE0000, 32'h0000FFFF, lmem[1]);
    run(16'h0004, 2'd2, 2'd0);
    exp_flt("R6 dpl ne cpl", 2'd1, 16'h0004);
    run(16'h003B, 2'd2, 2'd3);
    exp_flt("R6 read-only", 2'd1, 16'h0038);
    run(16'h0008, 2'd2, 2'd0);
    exp_flt("R6 code as stack", 2'd1, 16'h0008);
  endtask

  task automatic t_ds();
    run(16'h0028, 2'd0, 2'd0);
    exp_flt("R7 exec-only", 2'd1, 16'h0028);
    run(16'h000F, 2'd3, 2'd3);
    exp_flt("R7 dpl lt cpl", 2'd1, 16'h000C);
    run(16'h0020, 2'd0, 2'd3);
    chk("R7 conforming skips priv", {31'd0, ok}, 32'd1);
    run(16'h003B, 2'd0, 2'd3);
    chk("R7 read-only data ok", {31'd0, ok}, 32'd1);
    run(16'h0011, 2'd0, 2'd0);
    exp_flt("R7 dpl lt rpl", 2'd1, 16'h0010);
  endtask

  task automatic t_present();
    run(16'h0030, 2'd2, 2'd0);
    exp_flt("R8 absent", 2'd2, 16'h0030);
    run(16'h0030, 2'd1, 2'd0);
    exp_flt("R8 type before present", 2'd1, 16'h0030);
  endtask

  task automatic t_busy_start();
    int dn;
    @(negedge clk);
    stall = 1'b1; sel = 16'h0008; tgt = 2'd1; cpl = 2'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R11 busy after start", {31'd0, busy}, 32'd1);
    repeat (3) @(negedge clk);
    sel = 16'h0018; tgt = 2'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    stall = 1'b0;
    dn = 0;
    repeat (12) begin
      @(negedge clk);
      if (done) begin
        dn++;
        chk("R11 first request kept", {31'd0, ok}, 32'd1);
        chk("R11 first base", seg_base, 32'h12345678);
      end
    end
    chk("R11 single done", dn, 32'd1);
    chk("R11 idle after", {31'd0, busy}, 32'd0);
  endtask

  initial begin
    checks = 0; errors = 0; wd = 0;
    rst_n = 1'b0; start = 1'b0; stall = 1'b0;
    sel = '0; tgt = '0; cpl = '0;
    gdt_base = 32'h1000; gdt_lim = 32'h3F;
    ldt_base = 32'h2000; ldt_lim = 32'h17;
    for (int i = 0; i < 16; i++) gmem[i] = '0;
    for (int i = 0; i < 8; i++) lmem[i] = '0;
    put_g(1, mkd(32'h12345678, 20'hABCDE, 4'hA, 1'b1, 2'd0, 1'b1, 1'b0));
    put_g(2, mkd(32'h00FF0000, 20'h00012, 4'h2, 1'b1, 2'd0, 1'b1, 1'b1));
    put_g(3, mkd(32'h00001000, 20'h00FFF, 4'h2, 1'b0, 2'd0, 1'b1, 1'b0));
    put_g(4, mkd(32'h00400000, 20'h0FFFF, 4'hE, 1'b1, 2'd3, 1'b1, 1'b0));
    put_g(5, mkd(32'h00500000, 20'h0FFFF, 4'h8, 1'b1, 2'd0, 1'b1, 1'b0));
    put_g(6, mkd(32'h00600000, 20'h0FFFF, 4'h2, 1'b1, 2'd0, 1'b0, 1'b0));
    put_g(7, mkd(32'h00700000, 20'h0FFFF, 4'h0, 1'b1, 2'd3, 1'b1, 1'b0));
    put_l(0, mkd(32'hCAFE0000, 20'h0FFFF, 4'h2, 1'b1, 2'd3, 1'b1, 1'b0));
    put_l(1, mkd(32'h00110000, 20'h00FFF, 4'h2, 1'b1, 2'd0, 1'b1, 1'b0));
    put_l(2, mkd(32'h00220000, 20'h00FFF, 4'hA, 1'b1, 2'd0, 1'b1, 1'b0));
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_gdt_code();
    t_gran();
    t_null();
    t_bound();
    t_sys();
    t_cs();
    t_ss();
    t_ds();
    t_present();
    t_busy_start();
    if (wd >= 100000) begin
      errors++;
      checks++;
      $display("FAIL R11 watchdog actual=hung expected=done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule